// File: doc/BRIEF.md
# Timer Compare and Offset Counter Unit

This block sits next to a core's control registers. It watches a free-running 64-bit real-time count and a 64-bit alarm threshold, and it raises a sticky machine timer-pending flag once the count reaches the threshold. Writing a new threshold clears the flag. The flag is held by a two-state machine. In state ARMED the flag is low. The "expire" transition moves it to FIRED when the count is at or above the threshold. The "rearm" transition, taken on any threshold write, moves it back to ARMED.

The block also gives software views of time and of the retired-instruction count. The machine time view is read-only and reflects the raw count. The user time view, the user cycle view and the user instret view are writable. A write does not change the underlying counter. It stores a signed difference, the offset, and each read returns the base plus that offset. The cycle and instret views share one offset over an internal retired-instruction counter.

Accesses can be full 64-bit (wide mode) or split into 32-bit halves (narrow mode). In narrow mode a half write adjusts only the matching half of the offset. Read data and the error flag appear one cycle after the access.

Top module: `rtc_delta_csr`

## Requirements
- R1: After reset the timer-pending flag, read data and error flag are 0, and both offsets and the retire counter are 0. The threshold resets to all ones, and a wide read of selector 8 returns 64'hFFFF_FFFF_FFFF_FFFF.
- R2: The timer-pending flag rises on the cycle after one in which the count is greater than or equal to the threshold and no threshold write occurs. It then stays high, even if the count falls, until a threshold write.
- R3: A write to the threshold (selector 8, always all 64 bits in either mode; reads of selector 8 also return all 64 bits) loads the new value and clears the pending flag on the next cycle. If the new threshold is already reached, the flag rises again on the cycle after that.
- R4: Selectors 0 (low) and 1 (high) are machine time. Writes to them have no effect. A wide low read returns the count. A narrow low read returns count[31:0] zero-extended. A narrow high read returns count[63:32] zero-extended.
- R5: Selectors 2 (low) and 3 (high) are user time. A wide low write stores offset = wdata − count. A read returns count + offset, in full (wide) or as the zero-extended half (narrow).
- R6: A narrow low write to a user view replaces offset[31:0] with (wdata − base)[31:0] and leaves offset[63:32] unchanged.
- R7: A narrow high write to a user view sets offset[63:32] to (({wdata[31:0], 32'h0}) − base) >> 32 and leaves offset[31:0] unchanged.
- R8: Selectors 4/5 (cycle) and 6/7 (instret) share a single offset over the retire counter. A write through either view is seen by reads of both.
- R9: The retire counter increments by one on each cycle with retire_i high. Reads and offset writes in a given cycle use the counter value from before that cycle's increment.
- R10: In wide mode, a high-half selector (1, 3, 5, 7) is illegal. The error flag goes high for one cycle, the read data is 0, and a write has no effect.
- R11: Selectors 9 to 15 are illegal in either mode. They raise the error flag, return 0 and change nothing.
- R12: Read data is registered. It appears one cycle after a legal read and is 0 after a write, an illegal access or a cycle without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_i | input | 64 | Free-running real-time count |
| retire_i | input | 1 | Retire counter increment |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 4 | Register selector (see requirements) |
| acc_narrow_i | input | 1 | 1 = 32-bit split access, 0 = 64-bit |
| acc_wdata_i | input | 64 | Write data |
| rd_data_o | output | 64 | Registered read data |
| acc_err_o | output | 1 | Illegal access, one cycle after the access |
| timer_pend_o | output | 1 | Sticky machine timer-pending flag |

## Verification
The assertions check the following on every cycle:
- the expire and rearm transitions of the alarm machine;
- that a flag already FIRED stays high without a threshold write;
- that a narrow half write leaves the other half of an offset untouched;
- that the retire counter steps only when asked;
- that illegal or absent accesses return zero.

Only the bench's scenarios can show some behaviours:
- the arithmetic of the offsets, including the borrow across the 32-bit boundary on a high-half write;
- that the cycle and instret views share one offset;
- that ignored or illegal writes leave every view unchanged.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_CMP = 4'd8;

    typedef enum logic [2:0] {
        FAM_MTIME,
        FAM_UTIME,
        FAM_COUNT,
        FAM_CMP,
        FAM_BAD
    } fam_e;

    typedef enum logic {
        ALM_ARMED,
        ALM_FIRED
    } alm_state_e;

    function automatic fam_e sel_family(input logic [SEL_W-1:0] s);
        fam_e f;
        if (s == SEL_CMP)      f = FAM_CMP;
        else if (s[3])         f = FAM_BAD;
        else if (s[2:1] == 2'd0) f = FAM_MTIME;
        else if (s[2:1] == 2'd1) f = FAM_UTIME;
        else                   f = FAM_COUNT;
        return f;
    endfunction

endpackage

// File: rtl/rdc_alarm.sv
module rdc_alarm
    import rdc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rtc_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cmp_o,
    output logic         pend_o
);
    alm_state_e   state_q, state_d;
    logic [W-1:0] cmp_q;
    logic         reached;

    assign reached = (rtc_i >= cmp_q);
    assign cmp_o   = cmp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALM_ARMED;
            cmp_q   <= '1;
        end else begin
            state_q <= state_d;
            if (cmp_wr_i) cmp_q <= wdata_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_ARMED: if (!cmp_wr_i && reached) state_d = ALM_FIRED;
            ALM_FIRED: if (cmp_wr_i)             state_d = ALM_ARMED;
            default:                             state_d = ALM_ARMED;
        endcase
    end

    always_comb begin
        pend_o = (state_q == ALM_FIRED);
    end

    // R3
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> !pend_o);
    // R2
    expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr_i && (rtc_i >= cmp_o)) |=> pend_o);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !cmp_wr_i) |=> pend_o);
endmodule

// File: rtl/rdc_offset.sv
module rdc_offset #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] base_i,
    input  logic         wr_full_i,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] view_o
);
    localparam int HALF = W / 2;

    logic [W-1:0]    delta_q;
    logic [W-1:0]    diff;
    logic [HALF-1:0] hi_diff;

    assign diff    = wdata_i - base_i;
    assign hi_diff = wdata_i[HALF-1:0] - base_i[W-1:HALF]
                   - {{(HALF-1){1'b0}}, |base_i[HALF-1:0]};
    assign view_o  = base_i + delta_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         delta_q <= '0;
        else if (wr_full_i) delta_q <= diff;
        else if (wr_lo_i)   delta_q[HALF-1:0] <= diff[HALF-1:0];
        else if (wr_hi_i)   delta_q[W-1:HALF] <= hi_diff;
    end

    // R10
    one_write_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_full_i, wr_lo_i, wr_hi_i}));
    // R6
    lo_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> delta_q[W-1:HALF] == $past(delta_q[W-1:HALF]));
    // R7
    hi_keeps_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_i |=> delta_q[HALF-1:0] == $past(delta_q[HALF-1:0]));
    // R5
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_full_i || wr_lo_i || wr_hi_i) |=> $stable(delta_q));
endmodule

// File: rtl/rdc_retire_cnt.sv
module rdc_retire_cnt #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R9
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> cnt_o == $past(cnt_o) + 1'b1);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/rtc_delta_csr.sv
module rtc_delta_csr
    import rdc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     rtc_i,
    input  logic             retire_i,
    input  logic             acc_valid_i,
    input  logic             acc_write_i,
    input  logic [SEL_W-1:0] acc_sel_i,
    input  logic             acc_narrow_i,
    input  logic [W-1:0]     acc_wdata_i,
    output logic [W-1:0]     rd_data_o,
    output logic             acc_err_o,
    output logic             timer_pend_o
);
    localparam int HALF = W / 2;

    fam_e         fam;
    logic         is_hi, legal, acc_rd, acc_wr;
    logic         ut_full, ut_lo, ut_hi, ct_full, ct_lo, ct_hi, cmp_wr;
    logic [W-1:0] cnt, cmp_val, ut_view, ct_view, src, rd_val;
    logic [W-1:0] rd_q;
    logic         err_q;

    assign fam    = sel_family(acc_sel_i);
    assign is_hi  = acc_sel_i[0] && (fam != FAM_CMP) && (fam != FAM_BAD);
    assign legal  = (fam != FAM_BAD) && !(is_hi && !acc_narrow_i);
    assign acc_rd = acc_valid_i && legal && !acc_write_i;
    assign acc_wr = acc_valid_i && legal && acc_write_i;

    assign ut_full = acc_wr && (fam == FAM_UTIME) && !acc_narrow_i;
    assign ut_lo   = acc_wr && (fam == FAM_UTIME) && acc_narrow_i && !is_hi;
    assign ut_hi   = acc_wr && (fam == FAM_UTIME) && acc_narrow_i && is_hi;
    assign ct_full = acc_wr && (fam == FAM_COUNT) && !acc_narrow_i;
    assign ct_lo   = acc_wr && (fam == FAM_COUNT) && acc_narrow_i && !is_hi;
    assign ct_hi   = acc_wr && (fam == FAM_COUNT) && acc_narrow_i && is_hi;
    assign cmp_wr  = acc_wr && (fam == FAM_CMP);

    rdc_alarm #(.W(W)) alarm_i (
        .clk(clk), .rst_n(rst_n), .rtc_i(rtc_i), .cmp_wr_i(cmp_wr),
        .wdata_i(acc_wdata_i), .cmp_o(cmp_val), .pend_o(timer_pend_o)
    );

    rdc_retire_cnt #(.W(W)) retire_i_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(retire_i), .cnt_o(cnt)
    );

    rdc_offset #(.W(W)) utime_i (
        .clk(clk), .rst_n(rst_n), .base_i(rtc_i), .wr_full_i(ut_full),
        .wr_lo_i(ut_lo), .wr_hi_i(ut_hi), .wdata_i(acc_wdata_i), .view_o(ut_view)
    );

    rdc_offset #(.W(W)) count_i (
        .clk(clk), .rst_n(rst_n), .base_i(cnt), .wr_full_i(ct_full),
        .wr_lo_i(ct_lo), .wr_hi_i(ct_hi), .wdata_i(acc_wdata_i), .view_o(ct_view)
    );

    always_comb begin
        unique case (fam)
            FAM_MTIME: src = rtc_i;
            FAM_UTIME: src = ut_view;
            FAM_COUNT: src = ct_view;
            default:   src = cmp_val;
        endcase
        if (fam == FAM_CMP || !acc_narrow_i) rd_val = src;
        else if (is_hi) rd_val = {{HALF{1'b0}}, src[W-1:HALF]};
        else            rd_val = {{HALF{1'b0}}, src[HALF-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            rd_q  <= acc_rd ? rd_val : '0;
            err_q <= acc_valid_i && !legal;
        end
    end

    assign rd_data_o = rd_q;
    assign acc_err_o = err_q;

    // R10
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err_o |-> rd_data_o == '0);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> (rd_data_o == '0) && !acc_err_o);
    // R11
    bad_sel_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_sel_i > SEL_CMP) |=> acc_err_o);
endmodule

// File: tb/rtc_delta_csr_tb_top.sv
module rtc_delta_csr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] rtc;
    logic         retire, valid, wr, narrow;
    logic [3:0]   sel;
    logic [W-1:0] wdata;
    logic [W-1:0] rd_data;
    logic         err, pend;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [W-1:0] m_tdel, m_cdel, m_cnt, m_cmp;
    bit           m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_delta_csr #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rtc_i(rtc), .retire_i(retire),
        .acc_valid_i(valid), .acc_write_i(wr), .acc_sel_i(sel),
        .acc_narrow_i(narrow), .acc_wdata_i(wdata),
        .rd_data_o(rd_data), .acc_err_o(err), .timer_pend_o(pend)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] new_delta(input logic [W-1:0] old, input logic [W-1:0] wd,
                                              input logic [W-1:0] base, input bit nar, input bit hi);
        logic [W-1:0] d;
        logic [W-1:0] t;
        d = old;
        if (!nar) d = wd - base;
        else if (!hi) begin
            t = wd - base;
            d[31:0] = t[31:0];
        end else begin
            t = ({wd[31:0], 32'h0} - base) >> 32;
            d[63:32] = t[31:0];
        end
        return d;
    endfunction

    task automatic cyc(input bit v, input bit w, input logic [3:0] s, input bit nar,
                       input logic [W-1:0] wd, input bit ret, input logic [W-1:0] r,
                       input string tag);
        bit known, hi, legal;
        logic [W-1:0] src, exp_rd;
        bit exp_err, exp_pend;
        string t;
        valid = v; wr = w; sel = s; narrow = nar; wdata = wd; retire = ret; rtc = r;
        known = (s <= 4'd8);
        hi    = s[0] && (s < 4'd8);
        legal = v && known && !(hi && !nar);
        if (s == 4'd8)     src = m_cmp;
        else if (s < 4'd2) src = r;
        else if (s < 4'd4) src = r + m_tdel;
        else               src = m_cnt + m_cdel;
        exp_rd = '0;
        if (legal && !w) begin
            if (s == 4'd8 || !nar) exp_rd = src;
            else if (hi)           exp_rd = {32'h0, src[63:32]};
            else                   exp_rd = {32'h0, src[31:0]};
        end
        exp_err  = v && !legal;
        exp_pend = (legal && w && s == 4'd8) ? 1'b0 : (m_pend || (r >= m_cmp));
        if (legal && w) begin
            if (s == 4'd8)                m_cmp  = wd;
            else if (s >= 4'd2 && s < 4'd4) m_tdel = new_delta(m_tdel, wd, r, nar, hi);
            else if (s >= 4'd4)           m_cdel = new_delta(m_cdel, wd, m_cnt, nar, hi);
        end
        m_pend = exp_pend;
        if (ret) m_cnt = m_cnt + 1;
        if (tag != "")          t = tag;
        else if (!v)            t = "R12";
        else if (!known)        t = "R11";
        else if (hi && !nar)    t = "R10";
        else if (s == 4'd8)     t = "R3";
        else if (s < 4'd2)      t = "R4";
        else if (s < 4'd4)      t = "R5";
        else                    t = "R8";
        @(posedge clk);
        @(negedge clk);
        check({t, " rdata"}, rd_data, exp_rd);
        check({t, " err"}, {63'h0, err}, {63'h0, exp_err});
        check("R2 pend", {63'h0, pend}, {63'h0, exp_pend});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        void'($urandom(32'd20240611));
        rst_n = 0; valid = 0; wr = 0; sel = 0; narrow = 0; wdata = 0; retire = 0; rtc = 64'd100;
        m_tdel = 0; m_cdel = 0; m_cnt = 0; m_cmp = '1; m_pend = 0;
        repeat (3) @(negedge clk);
        // R1 reset state of outputs
        check("R1 rdata", rd_data, '0);
        check("R1 err", {63'h0, err}, 64'h0);
        check("R1 pend", {63'h0, pend}, 64'h0);
        rst_n = 1;
        cyc(1, 0, 4'd8, 0, 0, 0, 64'd100, "R1");
        cyc(1, 0, 4'd2, 0, 0, 0, 64'd100, "R1");
        cyc(1, 0, 4'd6, 0, 0, 0, 64'd100, "R1");
        // R4 machine time writes ignored, reads reflect the count
        cyc(1, 1, 4'd0, 0, 64'd5, 0, 64'd120, "R4");
        cyc(1, 0, 4'd0, 0, 0, 0, 64'h1_2345_6789, "R4");
        cyc(1, 0, 4'd1, 1, 0, 0, 64'h1_2345_6789, "R4");
        cyc(1, 0, 4'd0, 1, 0, 0, 64'h1_2345_6789, "R4");
        // R5 user time offset
        cyc(1, 1, 4'd2, 0, 64'd1000, 0, 64'd100, "R5");
        cyc(1, 0, 4'd2, 0, 0, 0, 64'd150, "R5");
        // R6 narrow low write
        cyc(1, 1, 4'd2, 1, 64'h20, 0, 64'h1_0000_0010, "R6");
        cyc(1, 0, 4'd3, 1, 0, 0, 64'h1_0000_0010, "R6");
        cyc(1, 0, 4'd2, 0, 0, 0, 64'h1_0000_0010, "R6");
        // R7 narrow high write with a borrow from the low half
        cyc(1, 1, 4'd3, 1, 64'h7, 0, 64'h2_0000_0001, "R7");
        cyc(1, 0, 4'd2, 0, 0, 0, 64'h2_0000_0001, "R7");
        cyc(1, 0, 4'd3, 1, 0, 0, 64'h2_0000_0005, "R7");
        // R9 retire counting and same-cycle write
        cyc(0, 0, 4'd0, 0, 0, 1, 64'd10, "R9");
        cyc(0, 0, 4'd0, 0, 0, 1, 64'd10, "R9");
        cyc(1, 1, 4'd6, 0, 64'd500, 1, 64'd10, "R9");
        cyc(1, 0, 4'd6, 0, 0, 0, 64'd10, "R9");
        // R8 cycle and instret share one offset
        cyc(1, 1, 4'd4, 0, 64'hABCD, 0, 64'd10, "R8");
        cyc(1, 0, 4'd6, 0, 0, 0, 64'd10, "R8");
        cyc(1, 1, 4'd7, 1, 64'h3, 0, 64'd10, "R8");
        cyc(1, 0, 4'd5, 1, 0, 0, 64'd10, "R8");
        // R10 wide high access illegal, write has no effect
        cyc(1, 1, 4'd3, 0, 64'hFFFF, 0, 64'd10, "R10");
        cyc(1, 0, 4'd1, 0, 0, 0, 64'd10, "R10");
        cyc(1, 0, 4'd2, 0, 0, 0, 64'd10, "R10");
        // R11 unknown selectors
        cyc(1, 1, 4'd12, 1, 64'h1, 0, 64'd10, "R11");
        cyc(1, 0, 4'd15, 0, 0, 0, 64'd10, "R11");
        cyc(1, 0, 4'd8, 0, 0, 0, 64'd10, "R11");
        // R2 / R3 alarm sequence
        cyc(1, 1, 4'd8, 0, 64'd50, 0, 64'd40, "R3");
        cyc(0, 0, 4'd0, 0, 0, 0, 64'd49, "R2");
        cyc(0, 0, 4'd0, 0, 0, 0, 64'd50, "R2");
        cyc(0, 0, 4'd0, 0, 0, 0, 64'd20, "R2");
        cyc(1, 1, 4'd8, 0, 64'd5, 0, 64'd20, "R3");
        cyc(0, 0, 4'd0, 0, 0, 0, 64'd20, "R3");
        cyc(1, 1, 4'd8, 0, 64'd1000, 0, 64'd20, "R3");
        // R12 idle cycle
        cyc(0, 0, 4'd2, 0, 0, 0, 64'd20, "R12");
        // random phase
        r = 64'hFFFF_FF00;
        for (int i = 0; i < 4000; i++) begin
            bit v, w, nar, ret;
            logic [3:0] s;
            logic [W-1:0] wd;
            if ($urandom_range(0, 99) == 0) r = {$urandom, $urandom};
            else r = r + 64'($urandom_range(0, 3));
            v   = ($urandom_range(0, 3) != 0);
            w   = $urandom_range(0, 1);
            nar = $urandom_range(0, 1);
            ret = $urandom_range(0, 1);
            s   = ($urandom_range(0, 3) == 0) ? 4'd8 : 4'($urandom_range(0, 15));
            wd  = (s == 4'd8) ? r + 64'($urandom_range(0, 40)) : {$urandom, $urandom};
            cyc(v, w, s, nar, wd, ret, r, "");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule